// File: doc/BRIEF.md
# Configuration Load Start Sequencer

This block steers the start-up of a device whose logic is held in volatile memory and must be reloaded after each power cycle. A restart comes from the asynchronous reset, from the active-low program input, or from a one-cycle refresh command. After a restart the sequencer holds its open-drain init line low for a fixed number of cycles. It then lets the line go. On the first cycle the shared line reads high, it captures the 3-bit mode select, which picks the loading port.

Once a port is chosen, the sequencer watches a strobed serial bit stream for a 16-bit sync word. Bits before the sync word are discarded. A set number of bits after it are passed out as configuration payload. When the last payload bit has been taken, a done flag rises and the device is in user mode. Two faults are sticky: a mode code with no port, and a stream that runs too long without a sync word. Either one raises an error, pulls the init line low again and waits for a new program request.

Top module: `cfg_boot_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, init_n_o, done_o and err_o are all 0.
- R2: Once the program input has been released, or a refresh pulse taken, init_n_o stays 0 for exactly INIT_CYCLES clock edges and reads 1 after that edge.
- R3: After release, the mode select is not sampled while the external init line is held low; it is sampled on the first edge at which the line reads high.
- R4: Mode codes whose bit is set in PORT_MASK (default codes 0 to 3) are latched onto port_sel_o and start the sync search; any other code (default 4 to 7) sets err_o and drives init_n_o low.
- R5: The search shifts strobed bits in MSB first and matches 16'hBDB3 at any bit alignment; no bit before or of the sync word is flagged on payload_vld_o.
- R6: The PAYLOAD_BITS strobed bits after the sync word appear on payload_vld_o and payload_bit_o; done_o rises on the clock edge after the one that takes the last payload bit.
- R7: If HUNT_LIMIT strobed bits pass without a match (a match on the last allowed bit still counts), err_o is set and init_n_o goes low; a stream of all ones never matches.
- R8: In the error state, refresh pulses and serial bits have no effect; only the program input clears the error.
- R9: Driving the program input low in any state, user mode included, drops done_o and err_o and drives init_n_o low at the next edge.
- R10: A refresh pulse in user mode drops done_o and restarts the init phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| prog_req_n | input | 1 | Program request, active low, level |
| refresh_cmd | input | 1 | One-cycle refresh command |
| mode_sel | input | 3 | Port select code |
| sdata_i | input | 1 | Serial configuration bit |
| sdata_en | input | 1 | Strobe marking sdata_i as a new bit |
| init_line_i | input | 1 | Value read back from the shared init line |
| init_n_o | output | 1 | Init line drive; 0 pulls the line low |
| done_o | output | 1 | Load complete, user mode |
| err_o | output | 1 | Sticky load fault |
| port_sel_o | output | 3 | Latched port code |
| payload_vld_o | output | 1 | Current strobed bit is payload |
| payload_bit_o | output | 1 | Payload bit value |

## Verification
The init line is released INIT_CYCLES edges after a restart has been taken. The port decision lands one edge after the line reads high. payload_vld_o follows the strobe in the same cycle. done_o lags the last payload capture by one edge. The bench drives inputs on falling edges and counts whole clock periods from each stimulus to its result. It checks the cycle before each transition as well as the cycle of it. For the hunt limit and the late sync match, it counts strobes to the exact bit where the outcome flips.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
   typedef enum logic [2:0] {
      ST_INIT,
      ST_RELEASE,
      ST_HUNT,
      ST_LOAD,
      ST_SETTLE,
      ST_USER,
      ST_FAIL
   } boot_state_e;

   localparam int          MODE_W    = 3;
   localparam int          SYNC_W    = 16;
   localparam logic [15:0] SYNC_WORD = 16'hBDB3;
endpackage

// File: rtl/cfg_init_timer.sv
module cfg_init_timer #(
   parameter int INIT_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);
   localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("cfg_init_timer: INIT_CYCLES must be at least 1");
   end

   if (INIT_CYCLES == 1) begin : g_single
      assign expired = run & ~clear;
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt <= '0;
         else if (clear)    cnt <= '0;
         else if (run)      cnt <= cnt + 1'b1;
      end
      assign expired = run & ~clear & (cnt == CW'(INIT_CYCLES - 1));
   end
endmodule

// File: rtl/cfg_sync_hunter.sv
module cfg_sync_hunter #(
   parameter int          W           = 16,
   parameter logic [15:0] SYNC        = 16'hBDB3,
   parameter int          HUNT_LIMIT  = 4096,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic shift_en,
   input  logic bit_in,
   output logic match,
   output logic limit_hit
);
   localparam int HW = $clog2(HUNT_LIMIT);

   if (W != 16) begin : g_bad_w
      $error("cfg_sync_hunter: sync width must be 16");
   end
   if (HUNT_LIMIT < W) begin : g_bad_limit
      $error("cfg_sync_hunter: HUNT_LIMIT shorter than the sync word");
   end

   logic [W-1:0]  sr;
   logic [W-1:0]  sr_nxt;
   logic [HW-1:0] seen;

   if (MSB_FIRST) begin : g_msb
      assign sr_nxt = {sr[W-2:0], bit_in};
   end else begin : g_lsb
      assign sr_nxt = {bit_in, sr[W-1:1]};
   end

   // all-zero preload: the sync word starts with a one, so only stream bits can match
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         seen <= '0;
      end else if (clear) begin
         sr   <= '0;
         seen <= '0;
      end else if (shift_en) begin
         sr   <= sr_nxt;
         seen <= seen + 1'b1;
      end
   end

   assign match     = shift_en & (sr_nxt == SYNC);
   assign limit_hit = shift_en & ~match & (seen == HW'(HUNT_LIMIT - 1));
endmodule

// File: rtl/cfg_payload_counter.sv
module cfg_payload_counter #(
   parameter int PAYLOAD_BITS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bit_en,
   output logic last
);
   localparam int PW = (PAYLOAD_BITS > 1) ? $clog2(PAYLOAD_BITS) : 1;

   if (PAYLOAD_BITS < 1) begin : g_bad_len
      $error("cfg_payload_counter: PAYLOAD_BITS must be at least 1");
   end

   if (PAYLOAD_BITS == 1) begin : g_single
      assign last = bit_en & ~clear;
   end else begin : g_count
      logic [PW-1:0] taken;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       taken <= '0;
         else if (clear)   taken <= '0;
         else if (bit_en)  taken <= taken + 1'b1;
      end
      assign last = bit_en & ~clear & (taken == PW'(PAYLOAD_BITS - 1));
   end
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
   import cfg_boot_pkg::*;
#(
   parameter int         INIT_CYCLES  = 64,
   parameter int         PAYLOAD_BITS = 1024,
   parameter int         HUNT_LIMIT   = 4096,
   parameter logic [7:0] PORT_MASK    = 8'h0F,
   parameter bit         MSB_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_req_n,
   input  logic              refresh_cmd,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              sdata_i,
   input  logic              sdata_en,
   input  logic              init_line_i,
   output logic              init_n_o,
   output logic              done_o,
   output logic              err_o,
   output logic [MODE_W-1:0] port_sel_o,
   output logic              payload_vld_o,
   output logic              payload_bit_o
);
   if (PORT_MASK == 8'h00) begin : g_bad_mask
      $error("cfg_boot_seq: PORT_MASK enables no port");
   end

   boot_state_e       state;
   logic [MODE_W-1:0] port_q;
   logic              restart;
   logic              init_done;
   logic              sync_hit;
   logic              hunt_over;
   logic              load_last;
   logic              mode_ok;

   // refresh is not honoured once a fault is latched
   assign restart = ~prog_req_n | (refresh_cmd & (state != ST_FAIL));
   assign mode_ok = PORT_MASK[mode_sel];

   cfg_init_timer #(
      .INIT_CYCLES (INIT_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (restart | (state != ST_INIT)),
      .run     (state == ST_INIT),
      .expired (init_done)
   );

   cfg_sync_hunter #(
      .W          (SYNC_W),
      .SYNC       (SYNC_WORD),
      .HUNT_LIMIT (HUNT_LIMIT),
      .MSB_FIRST  (MSB_FIRST)
   ) u_hunt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state != ST_HUNT),
      .shift_en  ((state == ST_HUNT) & sdata_en),
      .bit_in    (sdata_i),
      .match     (sync_hit),
      .limit_hit (hunt_over)
   );

   cfg_payload_counter #(
      .PAYLOAD_BITS (PAYLOAD_BITS)
   ) u_load (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (state != ST_LOAD),
      .bit_en ((state == ST_LOAD) & sdata_en),
      .last   (load_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_INIT;
         port_q <= '0;
      end else if (restart) begin
         state  <= ST_INIT;
         port_q <= '0;
      end else begin
         unique case (state)
            ST_INIT:    if (init_done) state <= ST_RELEASE;
            ST_RELEASE: begin
               if (init_line_i) begin
                  if (mode_ok) begin
                     port_q <= mode_sel;
                     state  <= ST_HUNT;
                  end else begin
                     state  <= ST_FAIL;
                  end
               end
            end
            ST_HUNT: begin
               if (sync_hit)       state <= ST_LOAD;
               else if (hunt_over) state <= ST_FAIL;
            end
            ST_LOAD:    if (load_last) state <= ST_SETTLE;
            ST_SETTLE:  state <= ST_USER;
            ST_USER:    state <= ST_USER;
            ST_FAIL:    state <= ST_FAIL;
            default:    state <= ST_INIT;
         endcase
      end
   end

   assign init_n_o      = (state != ST_INIT) & (state != ST_FAIL);
   assign done_o        = (state == ST_USER);
   assign err_o         = (state == ST_FAIL);
   assign port_sel_o    = port_q;
   assign payload_vld_o = (state == ST_LOAD) & sdata_en;
   assign payload_bit_o = sdata_i;
endmodule

// File: rtl/cfg_boot_seq_chk.sv
module cfg_boot_seq_chk #(
   parameter int MODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_req_n,
   input logic              init_n_o,
   input logic              done_o,
   input logic              err_o,
   input logic [MODE_W-1:0] port_sel_o,
   input logic              payload_vld_o
);
   // R8: user mode and fault never coexist
   assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   // R9: program request aborts everything at the next edge
   assert_prog_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_req_n |=> (!done_o && !err_o && !init_n_o));

   // R6: done rises one edge after the edge that took the last payload bit
   assert_done_after_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(payload_vld_o, 2));

   // R4 / R7: a fault is only entered from a phase with the init line released
   assert_err_from_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(init_n_o));

   // R8: fault persists until a program request
   assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && prog_req_n) |=> err_o);

   // R5: payload only flows while loading
   assert_payload_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      payload_vld_o |-> (init_n_o && !done_o && !err_o));

   // R2: user mode keeps the init line released
   assert_done_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> init_n_o);

   // R4: latched port does not move in user mode
   assert_port_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(done_o)) |-> $stable(port_sel_o));
endmodule

bind cfg_boot_seq cfg_boot_seq_chk #(.MODE_W(cfg_boot_pkg::MODE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .prog_req_n    (prog_req_n),
   .init_n_o      (init_n_o),
   .done_o        (done_o),
   .err_o         (err_o),
   .port_sel_o    (port_sel_o),
   .payload_vld_o (payload_vld_o)
);

// File: tb/sim_cfg_boot_seq.sv
`timescale 1ns/1ps
module sim_cfg_boot_seq;
   localparam int INIT_C = 6;
   localparam int PAY_C  = 12;
   localparam int HUNT_C = 40;
   localparam logic [15:0] SYNC = 16'hBDB3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prog_req_n = 1'b1;
   logic       refresh_cmd = 1'b0;
   logic [2:0] mode_sel = 3'd0;
   logic       sdata_i = 1'b0;
   logic       sdata_en = 1'b0;
   logic       ext_hold_n = 1'b1;
   logic       init_line;
   logic       init_n_o, done_o, err_o, payload_vld_o, payload_bit_o;
   logic [2:0] port_sel_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   int vld_seen;
   int bit_bad;
   logic last_vld, last_bit;

   always #2.5 clk = ~clk;

   assign init_line = init_n_o & ext_hold_n;

   cfg_boot_seq #(
      .INIT_CYCLES  (INIT_C),
      .PAYLOAD_BITS (PAY_C),
      .HUNT_LIMIT   (HUNT_C)
   ) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .prog_req_n    (prog_req_n),
      .refresh_cmd   (refresh_cmd),
      .mode_sel      (mode_sel),
      .sdata_i       (sdata_i),
      .sdata_en      (sdata_en),
      .init_line_i   (init_line),
      .init_n_o      (init_n_o),
      .done_o        (done_o),
      .err_o         (err_o),
      .port_sel_o    (port_sel_o),
      .payload_vld_o (payload_vld_o),
      .payload_bit_o (payload_bit_o)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send_bit(logic b);
      sdata_i  = b;
      sdata_en = 1'b1;
      #1;
      last_vld = payload_vld_o;
      last_bit = payload_bit_o;
      @(negedge clk);
      sdata_en = 1'b0;
   endtask

   task automatic pulse_prog();
      @(negedge clk);
      prog_req_n = 1'b0;
      @(negedge clk);
      prog_req_n = 1'b1;
   endtask

   // after release: INIT_C edges low, then one edge to take the port decision
   task automatic open_port(string req);
      repeat (INIT_C - 1) @(negedge clk);
      chk(req, "init_n low before expiry", int'(init_n_o), 0);
      @(negedge clk);
      chk(req, "init_n released", int'(init_n_o), 1);
      @(negedge clk);
   endtask

   task automatic run_load(int off, logic fill, string req);
      mode_sel = 3'(off % 4);
      pulse_prog();
      open_port("R2");
      vld_seen = 0;
      for (int i = 0; i < off; i++) begin
         send_bit(fill);
         vld_seen += int'(last_vld);
      end
      for (int i = 15; i >= 0; i--) begin
         send_bit(SYNC[i]);
         vld_seen += int'(last_vld);
      end
      chk("R5", $sformatf("pre-sync payload strobes off=%0d", off), vld_seen, 0);
      vld_seen = 0;
      bit_bad  = 0;
      for (int i = 0; i < PAY_C; i++) begin
         logic b;
         b = logic'(((i * 7 + off) % 3) == 1);
         send_bit(b);
         vld_seen += int'(last_vld);
         if (last_bit != b) bit_bad++;
      end
      chk(req, $sformatf("payload strobes off=%0d", off), vld_seen, PAY_C);
      chk(req, "payload bit errors", bit_bad, 0);
      chk("R6", "done low on capture edge", int'(done_o), 0);
      @(negedge clk);
      chk("R6", "done high one edge later", int'(done_o), 1);
      chk("R4", "port held in user mode", int'(port_sel_o), off % 4);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "init_n in reset", int'(init_n_o), 0);
      chk("R1", "done in reset", int'(done_o), 0);
      chk("R1", "err in reset", int'(err_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "init_n after reset", int'(init_n_o), 0);
      chk("R1", "done after reset", int'(done_o), 0);

      // R4: sweep every mode code
      for (int m = 0; m < 8; m++) begin
         mode_sel = 3'(m);
         pulse_prog();
         open_port("R2");
         chk("R4", $sformatf("err for mode %0d", m), int'(err_o), (m > 3) ? 1 : 0);
         chk("R4", $sformatf("port for mode %0d", m), int'(port_sel_o), (m > 3) ? 0 : m);
         chk("R4", $sformatf("init_n for mode %0d", m), int'(init_n_o), (m > 3) ? 0 : 1);
      end

      // R3: external hold delays the mode sample
      for (int k = 0; k < 2; k++) begin
         mode_sel   = (k == 0) ? 3'd5 : 3'd2;
         ext_hold_n = 1'b0;
         pulse_prog();
         repeat (INIT_C + 5) @(negedge clk);
         chk("R3", "no decision while line held", int'(err_o), 0);
         chk("R3", "port idle while line held", int'(port_sel_o), 0);
         ext_hold_n = 1'b1;
         @(negedge clk);
         chk("R3", "decision after line high err", int'(err_o), (k == 0) ? 1 : 0);
         chk("R3", "decision after line high port", int'(port_sel_o), (k == 0) ? 0 : 2);
      end

      // R5 / R6: sync at every alignment, zero and one prefixes, plus late boundary
      for (int off = 0; off < 16; off++) run_load(off, logic'(off & 1), "R6");
      run_load(HUNT_C - 16, 1'b0, "R7");

      // R9: program request in user mode
      @(negedge clk);
      prog_req_n = 1'b0;
      @(negedge clk);
      chk("R9", "done drops on program", int'(done_o), 0);
      chk("R9", "init_n low on program", int'(init_n_o), 0);
      prog_req_n = 1'b1;

      // R10: refresh in user mode
      run_load(3, 1'b1, "R6");
      refresh_cmd = 1'b1;
      @(negedge clk);
      refresh_cmd = 1'b0;
      chk("R10", "done drops on refresh", int'(done_o), 0);
      open_port("R10");
      chk("R10", "port re-selected", int'(port_sel_o), 3);

      // R7: idle ones run out the hunt limit
      mode_sel = 3'd1;
      pulse_prog();
      open_port("R2");
      for (int i = 0; i < HUNT_C - 1; i++) send_bit(1'b1);
      chk("R7", "no error before limit", int'(err_o), 0);
      send_bit(1'b1);
      chk("R7", "error at limit", int'(err_o), 1);
      chk("R7", "init_n low at limit", int'(init_n_o), 0);

      // R8: fault ignores refresh and stream
      refresh_cmd = 1'b1;
      @(negedge clk);
      refresh_cmd = 1'b0;
      repeat (INIT_C + 2) @(negedge clk);
      vld_seen = 0;
      for (int i = 15; i >= 0; i--) begin
         send_bit(SYNC[i]);
         vld_seen += int'(last_vld);
      end
      for (int i = 0; i < PAY_C + 2; i++) begin
         send_bit(1'b0);
         vld_seen += int'(last_vld);
      end
      chk("R8", "error kept after refresh", int'(err_o), 1);
      chk("R8", "init_n kept low", int'(init_n_o), 0);
      chk("R8", "no payload in fault", vld_seen, 0);
      chk("R8", "no done in fault", int'(done_o), 0);
      pulse_prog();
      chk("R8", "program clears fault", int'(err_o), 0);
      run_load(7, 1'b0, "R6");

      summary();
      $finish;
   end
endmodule